// File: doc/BRIEF.md
# I2C Command Register Target

This block is an I2C target that gives a bus controller access to a bank of 128 byte-wide command registers. The bank lives outside the block and is reached through a plain register port: an address, a write strobe with write data, combinational read data, and a read-only flag that the bank returns for whichever address is presented. Inside the block a 7-bit pointer selects the register. A command byte sent after a write-addressed header loads the pointer. The pointer then steps by one on every acknowledged data byte.

The bus lines are oversampled by a fast system clock. Each line passes through a two-flop synchronizer and then a three-sample agreement filter before edges, START and STOP are decoded. SDA is driven only as an open-drain pull-down. SCL is never held, because the block does not stretch the clock. Four transaction shapes are served: a one-byte write, a one-byte read (command, repeated START, read header), an incremental read that continues for as long as the controller acknowledges, and a quick read that skips the command and reads from wherever the pointer already stands. A programmable watchdog returns the block to idle if the bus sits low for too long.

Top module: `i2cCmdRegTarget`

## Requirements
- R1: Only a header whose upper seven bits equal 1010101 is acknowledged (0xAA selects write, 0xAB selects read). Any other header is not acknowledged, and the rest of that transaction is ignored.
- R2: In a write transaction, a command byte of 0x7F or below is acknowledged and loads the pointer. The first data byte after it goes to that register when the register is writable.
- R3: The pointer steps by one whenever a data byte is acknowledged, whether the target or the controller gives the acknowledge. An incremental read therefore moves on from 0x7F to 0x00.
- R4: A command byte above 0x7F is not acknowledged. The pointer is unchanged and no register is written.
- R5: A data byte aimed at a read-only register is not acknowledged. No write strobe is issued, so the register keeps its value.
- R6: Only the first data byte of a write transaction can be accepted. Every later data byte in the same transaction is not acknowledged and is discarded.
- R7: A read header that follows START directly (quick read) returns data starting from the current pointer.
- R8: A repeated START at any point abandons the byte in progress and restarts header decoding. The pointer keeps its value and no register is written.
- R9: If SCL stays low, or SDA stays low while SCL is high, for more than `timeoutCycles` system clocks without an SCL edge, SDA is released and the block returns to idle. A value of zero turns this check off.
- R10: A pulse on SDA or SCL lasting fewer than three system clocks after synchronization is not seen as a level change, so it creates no false START or STOP.
- R11: Out of reset, SDA is released and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL level sensed from the bus |
| sdaIn | input | 1 | SDA level sensed from the bus |
| sdaPullLow | output | 1 | 1 pulls SDA low; 0 releases it |
| timeoutCycles | input | TO_W | Bus-stuck limit in system clocks; 0 disables it |
| regAddr | output | 7 | Register address, equal to the pointer |
| regWrEn | output | 1 | One-cycle write strobe for regAddr |
| regWrData | output | 8 | Data written on regWrEn |
| regRdData | input | 8 | Contents of the register at regAddr |
| regReadOnly | input | 1 | 1 when the register at regAddr is read-only |

## Verification
The bench looks for the places where the pointer is easy to get wrong. An incremental read that crosses 0x7F shows whether a design clears the pointer or runs past the bank. A quick read after a read that ended in NACK shows whether the pointer also stepped on the final, unacknowledged byte. A repeated START in the middle of a data byte catches a design that writes the partial byte or resets the pointer. Header, command and data bytes that must be refused (a foreign header, a command with bit 7 set, a read-only target, surplus write bytes) would show up as wrong ACK bits or corrupted registers when read back. A two-clock SDA glitch while SCL is high would end a transaction early in a design without the filter. Holding SCL low through an ACK slot, with the limit set and with it disabled, shows whether SDA is released exactly when it should be.

// File: rtl/i2cCmdRegPkg.sv
package i2cCmdRegPkg;
  localparam int BYTE_W = 8;
  localparam int REG_AW = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} phase_t;
  typedef enum logic [1:0] {K_ADDR, K_CMD, K_WDATA} rxKind_t;
  typedef enum logic [1:0] {N_IDLE, N_RX_CMD, N_RX_WDATA, N_TX} after_t;

  typedef struct packed {
    logic ptrLoad;
    logic ptrInc;
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic cntClear;
  } ctlStrobes_t;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic timedOut;
  } busEvents_t;
endpackage

// File: rtl/i2cCmdRegDatapath.sv
module i2cCmdRegDatapath
  import i2cCmdRegPkg::*;
#(
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3,
  parameter int TO_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [TO_W-1:0]   timeoutCycles,
  input  ctlStrobes_t       ctl,
  input  logic [BYTE_W-1:0] regRdData,
  output busEvents_t        ev,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txBit,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [REG_AW-1:0] ptr,
  output logic              sdaLevel
);
  logic [1:0] rawIn, lineF, lineP;
  assign rawIn = {sclIn, sdaIn};

  // index 1 = SCL, index 0 = SDA
  for (genvar g = 0; g < 2; g++) begin : gLine
    logic [SYNC_LEN-1:0] syncQ;
    logic [FILT_LEN-1:0] histQ;
    logic fQ, pQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '1;
        histQ <= '1;
        fQ    <= 1'b1;
        pQ    <= 1'b1;
      end else begin
        syncQ <= {syncQ[SYNC_LEN-2:0], rawIn[g]};
        histQ <= {histQ[FILT_LEN-2:0], syncQ[SYNC_LEN-1]};
        if (&histQ)       fQ <= 1'b1;
        else if (~|histQ) fQ <= 1'b0;
        pQ <= fQ;
      end
    end
    assign lineF[g] = fQ;
    assign lineP[g] = pQ;
  end

  logic sclF, sdaF, sclP, sdaP;
  assign sclF = lineF[1];
  assign sdaF = lineF[0];
  assign sclP = lineP[1];
  assign sdaP = lineP[0];
  assign sdaLevel = sdaF;

  logic [TO_W-1:0] toCnt;
  logic [BYTE_W-1:0] txReg;

  assign ev.sclRise   = sclF & ~sclP;
  assign ev.sclFall   = ~sclF & sclP;
  assign ev.startSeen = sclF & sclP & sdaP & ~sdaF;
  assign ev.stopSeen  = sclF & sclP & ~sdaP & sdaF;
  assign ev.timedOut  = (timeoutCycles != '0) && (toCnt >= timeoutCycles);
  assign txBit = txReg[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toCnt  <= '0;
      rxByte <= '0;
      txReg  <= '1;
      bitCnt <= '0;
      ptr    <= '0;
    end else begin
      if (ev.sclRise || ev.sclFall || (sclF && sdaF)) toCnt <= '0;
      else if (toCnt != '1)                           toCnt <= toCnt + 1'b1;

      if (ctl.cntClear) bitCnt <= '0;
      if (ctl.rxShift) begin
        rxByte <= {rxByte[BYTE_W-2:0], sdaF};
        bitCnt <= bitCnt + 1'b1;
      end
      if (ctl.txLoad) begin
        txReg  <= regRdData;
        bitCnt <= '0;
      end
      if (ctl.txShift) begin
        txReg  <= {txReg[BYTE_W-2:0], 1'b1};
        bitCnt <= bitCnt + 1'b1;
      end

      if (ctl.ptrLoad)     ptr <= rxByte[REG_AW-1:0];
      else if (ctl.ptrInc) ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/i2cCmdRegControl.sv
module i2cCmdRegControl
  import i2cCmdRegPkg::*;
#(
  parameter logic [REG_AW-1:0] TARGET_ADDR = 7'h55
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvents_t        ev,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic              txBit,
  input  logic              sdaLevel,
  input  logic              regReadOnly,
  output ctlStrobes_t       ctl,
  output logic              wrStrobe,
  output logic              sdaPullLow
);
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

  phase_t  phase, phaseN;
  rxKind_t kind, kindN;
  after_t  after, afterN;
  logic    ackDrive, ackN, firstData, firstN, mAck, mAckN;

  always_comb begin
    phaseN = phase; kindN = kind; afterN = after;
    ackN = ackDrive; firstN = firstData; mAckN = mAck;
    ctl = '0;
    wrStrobe = 1'b0;
    if (ev.timedOut || ev.stopSeen) begin
      phaseN = ST_IDLE;
    end else if (ev.startSeen) begin
      phaseN = ST_RX;
      kindN = K_ADDR;
      ctl.cntClear = 1'b1;
    end else begin
      case (phase)
        ST_RX: begin
          if (ev.sclRise && bitCnt < FULL) begin
            ctl.rxShift = 1'b1;
          end else if (ev.sclFall && bitCnt == FULL) begin
            phaseN = ST_ACK;
            case (kind)
              K_ADDR: begin
                ackN   = (rxByte[BYTE_W-1:1] == TARGET_ADDR);
                afterN = !ackN ? N_IDLE : (rxByte[0] ? N_TX : N_RX_CMD);
              end
              K_CMD: begin
                ackN   = !rxByte[BYTE_W-1];
                afterN = ackN ? N_RX_WDATA : N_IDLE;
                firstN = 1'b1;
                ctl.ptrLoad = ackN;
              end
              default: begin
                ackN       = firstData && !regReadOnly;
                wrStrobe   = ackN;
                ctl.ptrInc = ackN;
                firstN     = 1'b0;
                afterN     = N_RX_WDATA;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (ev.sclFall) begin
            case (after)
              N_RX_CMD:   begin phaseN = ST_RX; kindN = K_CMD;   ctl.cntClear = 1'b1; end
              N_RX_WDATA: begin phaseN = ST_RX; kindN = K_WDATA; ctl.cntClear = 1'b1; end
              N_TX:       begin phaseN = ST_TX; ctl.txLoad = 1'b1; end
              default:    phaseN = ST_IDLE;
            endcase
          end
        end
        ST_TX: begin
          if (ev.sclFall) begin
            if (bitCnt == LAST_TX) phaseN = ST_MACK;
            else                   ctl.txShift = 1'b1;
          end
        end
        ST_MACK: begin
          if (ev.sclRise) begin
            mAckN = !sdaLevel;
            ctl.ptrInc = !sdaLevel;
          end else if (ev.sclFall) begin
            if (mAck) begin phaseN = ST_TX; ctl.txLoad = 1'b1; end
            else          phaseN = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= ST_IDLE; kind <= K_ADDR; after <= N_IDLE;
      ackDrive <= 1'b0; firstData <= 1'b0; mAck <= 1'b0;
    end else begin
      phase <= phaseN; kind <= kindN; after <= afterN;
      ackDrive <= ackN; firstData <= firstN; mAck <= mAckN;
    end
  end

  assign sdaPullLow = ((phase == ST_ACK) && ackDrive) || ((phase == ST_TX) && !txBit);
endmodule

// File: rtl/i2cCmdRegTarget.sv
module i2cCmdRegTarget
  import i2cCmdRegPkg::*;
#(
  parameter logic [REG_AW-1:0] TARGET_ADDR = 7'h55,
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3,
  parameter int TO_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  input  logic [TO_W-1:0]   timeoutCycles,
  output logic [REG_AW-1:0] regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  input  logic [BYTE_W-1:0] regRdData,
  input  logic              regReadOnly
);
  ctlStrobes_t ctl;
  busEvents_t  ev;
  logic [BYTE_W-1:0] rxByte;
  logic [CNT_W-1:0]  bitCnt;
  logic txBit, sdaLevel;

  i2cCmdRegDatapath #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN), .TO_W(TO_W)) dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .timeoutCycles(timeoutCycles), .ctl(ctl), .regRdData(regRdData),
    .ev(ev), .rxByte(rxByte), .txBit(txBit), .bitCnt(bitCnt),
    .ptr(regAddr), .sdaLevel(sdaLevel)
  );

  i2cCmdRegControl #(.TARGET_ADDR(TARGET_ADDR)) ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte), .bitCnt(bitCnt),
    .txBit(txBit), .sdaLevel(sdaLevel), .regReadOnly(regReadOnly),
    .ctl(ctl), .wrStrobe(regWrEn), .sdaPullLow(sdaPullLow)
  );

  assign regWrData = rxByte;
endmodule

// File: rtl/i2cCmdRegTargetChk.sv
module i2cCmdRegTargetChk #(
  parameter int TO_W = 16,
  parameter int AW   = 7
) (
  input logic            clk,
  input logic            rstN,
  input logic            sclIn,
  input logic            sdaPullLow,
  input logic [TO_W-1:0] timeoutCycles,
  input logic [AW-1:0]   regAddr,
  input logic            regWrEn,
  input logic            regReadOnly
);
  localparam logic [TO_W:0] MARGIN = (TO_W + 1)'(16);

  logic [TO_W:0] lowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           lowCnt <= '0;
    else if (sclIn)      lowCnt <= '0;
    else if (lowCnt != '1) lowCnt <= lowCnt + 1'b1;
  end

  AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !regReadOnly); // R5

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn); // R6

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regAddr == AW'($past(regAddr) + 1'b1))); // R3

  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    ((timeoutCycles != '0) && (lowCnt > ({1'b0, timeoutCycles} + MARGIN))) |-> !sdaPullLow); // R9
endmodule

bind i2cCmdRegTarget i2cCmdRegTargetChk #(.TO_W(TO_W), .AW(REG_AW)) chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .timeoutCycles(timeoutCycles), .regAddr(regAddr), .regWrEn(regWrEn),
  .regReadOnly(regReadOnly)
);

// File: tb/i2cCmdRegTarget_test.sv
`timescale 1ns/1ps
module i2cCmdRegTarget_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sdaPullLow, regWrEn, regReadOnly;
  logic [15:0] timeoutCycles = 16'd100;
  logic [6:0] regAddr;
  logic [7:0] regWrData, regRdData;
  wire sdaBus = mSda & ~sdaPullLow;

  always #2 clk = ~clk;

  logic [7:0] mem [128];
  logic [7:0] exp [128];
  logic [6:0] expPtr = 7'd0;
  int checkCnt = 0, failCnt = 0;

  function automatic logic roFn(input logic [6:0] a);
    return a[1:0] == 2'b11;
  endfunction
  function automatic logic [7:0] initVal(input int i);
    return 8'(i * 37 + 5);
  endfunction

  assign regRdData = mem[regAddr];
  assign regReadOnly = roFn(regAddr);

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 128; i++) mem[i] <= initVal(i);
    end else if (regWrEn) mem[regAddr] <= regWrData;
  end

  i2cCmdRegTarget uut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus),
    .sdaPullLow(sdaPullLow), .timeoutCycles(timeoutCycles),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .regReadOnly(regReadOnly)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checkCnt++;
    if (act !== expv) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask
  task automatic sendStart(); mSda = 1; mScl = 1; waitQ(); mSda = 0; waitQ(); mScl = 0; waitQ(); endtask
  task automatic sendRepStart(); mSda = 1; waitQ(); mScl = 1; waitQ(); mSda = 0; waitQ(); mScl = 0; waitQ(); endtask
  task automatic sendStop(); mSda = 0; waitQ(); mScl = 1; waitQ(); mSda = 1; waitQ(); waitQ(); endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      mSda = b[7-i]; waitQ(); mScl = 1; waitQ(); waitQ(); mScl = 0; waitQ();
    end
  endtask

  task automatic ackSlot(output logic acked);
    mSda = 1; waitQ(); mScl = 1; waitQ(); acked = (sdaBus == 1'b0); waitQ(); mScl = 0; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, output logic acked);
    sendBits(b, 8);
    ackSlot(acked);
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] b);
    mSda = 1;
    for (int i = 0; i < 8; i++) begin
      waitQ(); mScl = 1; waitQ(); b = {b[6:0], sdaBus}; waitQ(); mScl = 0;
    end
    waitQ();
    mSda = giveAck ? 1'b0 : 1'b1; waitQ(); mScl = 1; waitQ(); waitQ(); mScl = 0; waitQ(); mSda = 1;
  endtask

  task automatic readLoop(input int n);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      readByte(k < n - 1, d);
      chk("R3/R7 read data", d, exp[expPtr]);
      if (k < n - 1) expPtr++;
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [7:0] d);
    logic ak;
    sendStart();
    writeByte(8'hAA, ak); chk("R1 write header ack", ak, 1);
    writeByte(a, ak);     chk("R2/R4 command ack", ak, a < 8'h80);
    if (a < 8'h80) begin
      expPtr = a[6:0];
      writeByte(d, ak);   chk("R5 data ack", ak, !roFn(a[6:0]));
      if (!roFn(a[6:0])) begin exp[a[6:0]] = d; expPtr++; end
    end
    sendStop();
  endtask

  task automatic doRead(input logic [6:0] a, input int n);
    logic ak;
    sendStart();
    writeByte(8'hAA, ak); chk("R1 write header ack", ak, 1);
    writeByte({1'b0, a}, ak); chk("R2 command ack", ak, 1);
    expPtr = a;
    sendRepStart();
    writeByte(8'hAB, ak); chk("R1 read header ack", ak, 1);
    readLoop(n);
    sendStop();
  endtask

  task automatic quickRead(input int n);
    logic ak;
    sendStart();
    writeByte(8'hAB, ak); chk("R7 quick header ack", ak, 1);
    readLoop(n);
    sendStop();
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic ak;
    logic [7:0] d;
    void'($urandom(32'h1C2D));
    for (int i = 0; i < 128; i++) exp[i] = initVal(i);
    repeat (5) @(negedge clk);
    chk("R11 reset sda released", sdaPullLow, 0);
    chk("R11 reset no strobe", regWrEn, 0);
    rstN = 1;
    repeat (10) @(negedge clk);
    chk("R11 idle sda released", sdaPullLow, 0);

    // R2 basic write then one-byte read
    doWrite(8'h10, 8'h5A);
    doRead(7'h10, 1);

    // R1 foreign header ignored, pointer kept
    sendStart(); writeByte(8'hA4, ak); chk("R1 foreign header nack", ak, 0); sendStop();
    quickRead(1);

    // R4 command above 0x7F
    sendStart(); writeByte(8'hAA, ak); writeByte(8'h85, ak);
    chk("R4 high command nack", ak, 0); sendStop();
    quickRead(1);

    // R5 read-only target
    doWrite(8'h13, 8'hC3);
    doRead(7'h13, 1);

    // R6 surplus write bytes
    sendStart(); writeByte(8'hAA, ak); writeByte(8'h20, ak); expPtr = 7'h20;
    writeByte(8'h11, ak); chk("R6 first data ack", ak, 1); exp[7'h20] = 8'h11; expPtr++;
    writeByte(8'h22, ak); chk("R6 second data nack", ak, 0);
    writeByte(8'h33, ak); chk("R6 third data nack", ak, 0);
    sendStop();
    doRead(7'h20, 2);

    // R3 wrap, then R7 quick read from pointer left after NACK
    doRead(7'h7E, 4);
    quickRead(2);

    // R8 repeated start inside a data byte
    sendStart(); writeByte(8'hAA, ak); writeByte(8'h30, ak); expPtr = 7'h30;
    sendBits(8'hA0, 3);
    sendRepStart();
    writeByte(8'hAB, ak); chk("R8 header after restart", ak, 1);
    readByte(1'b0, d); chk("R8 pointer kept, no write", d, exp[7'h30]);
    sendStop();

    // R10 two-clock SDA glitch while SCL high
    sendStart(); writeByte(8'hAA, ak); writeByte(8'h40, ak); expPtr = 7'h40;
    sendBits(8'h7E, 1);
    mSda = 1; waitQ(); mScl = 1; waitQ();
    mSda = 0; repeat (2) @(negedge clk); mSda = 1; waitQ(); mScl = 0; waitQ();
    sendBits(8'(8'h7E << 2), 6);
    ackSlot(ak); chk("R10 glitch ignored, data ack", ak, 1);
    exp[7'h40] = 8'h7E; expPtr++;
    sendStop();
    doRead(7'h40, 1);

    // R9 timeout releases SDA held in ACK slot
    sendStart(); writeByte(8'hAA, ak); sendBits(8'h05, 8); expPtr = 7'h05;
    waitQ(); chk("R9 ack driven before hold", sdaPullLow, 1);
    repeat (150) @(negedge clk);
    chk("R9 sda released after timeout", sdaPullLow, 0);
    sendStop();
    quickRead(1);

    // R9 zero disables timeout
    timeoutCycles = 16'd0;
    sendStart(); writeByte(8'hAA, ak); sendBits(8'h06, 8); expPtr = 7'h06;
    repeat (300) @(negedge clk);
    chk("R9 disabled, ack still driven", sdaPullLow, 1);
    mSda = 1; mScl = 1; waitQ(); waitQ(); mScl = 0; waitQ();
    writeByte(8'h9C, ak); chk("R9 disabled, transfer continues", ak, 1);
    exp[7'h06] = 8'h9C; expPtr++;
    sendStop();
    timeoutCycles = 16'd100;
    doRead(7'h06, 1);

    // random mix
    for (int it = 0; it < 30; it++) begin
      int op;
      op = $urandom_range(0, 2);
      if (op == 0) doWrite(8'($urandom_range(0, 140)), 8'($urandom));
      else if (op == 1) doRead(7'($urandom_range(0, 127)), $urandom_range(1, 4));
      else quickRead($urandom_range(1, 3));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule